// File: doc/BRIEF.md
# Time-Shared Keypad Matrix and Indicator Scanner

This block runs an operator panel over a single group of strobe lines. The panel has a key matrix of strobe rows and return columns, and a row of indicator LEDs that shares the same strobe wires. Each scan cycle has two parts. First, every strobe row is pulled low in turn for a programmable number of clock cycles, and the return columns are read at the last cycle of that slot. Then one more slot of the same length puts the LED pattern on the strobe wires. During that slot a separate flag tells the panel that the wires now carry indicator data, and no key reading takes place.

The return columns have pull-ups, so a closed key reads low. Each raw reading goes through a filter. A key's reported level changes only after the same reading has been seen in three scan cycles in a row. The block reports the filtered state of all keys as one vector. It also gives a one-cycle pulse each time a row reading changes any filtered bit.

Top module: `kps_panel_scanner`

## Requirements
- R1: During reset and just after it, `key_down` is all zero, `key_changed` is 0, `led_phase` is 0, and `strobe_n` has only row 0 driven low (8'hFE with the default size).
- R2: Outside the LED slot, exactly one `strobe_n` bit is low. Rows are visited in ascending order 0,1,...,NUM_STROBE-1, and each row is held for `dwell_cycles` clock cycles.
- R3: Right after the last row, one slot of the same length follows. In that slot `led_phase` is 1 and `strobe_n` equals `led_pattern`. At all other times `led_phase` is 0.
- R4: The bit for a key is at index row*NUM_RETURN + column. A 1 in `key_down` means pressed, and a low return column means pressed.
- R5: A key's bit in `key_down` changes only when the same reading has been taken for it in three consecutive scan cycles. Any reading sequence shorter than that leaves the bit unchanged.
- R6: The levels on `ret_n` during the LED slot have no effect on `key_down`.
- R7: `key_changed` is high for exactly one cycle for each row reading that changes at least one `key_down` bit. It rises in the same cycle that the new `key_down` value appears.
- R8: A `dwell_cycles` value of 0 is treated as 1. Each slot then lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dwell_cycles | input | DWELL_W | Slot length in clock cycles (0 acts as 1) |
| led_pattern | input | NUM_STROBE | Levels placed on the strobe lines during the LED slot |
| ret_n | input | NUM_RETURN | Return columns, low when a key on the active row is closed |
| strobe_n | output | NUM_STROBE | Shared strobe lines: one low per key slot, or the LED pattern |
| led_phase | output | 1 | High while the strobe lines carry LED data |
| key_down | output | NUM_STROBE*NUM_RETURN | Filtered key state, 1 = pressed |
| key_changed | output | 1 | One-cycle pulse when a row reading changes `key_down` |

## Verification
The bench builds the block with its default size: eight strobe rows, four return columns, an 8-bit slot length and a three-reading filter. With that size the full 32-key index map and the row order can be observed directly at the ports. Slot lengths of 0, 1, 2, 3 and 5 are used, so a full scan cycle takes at most a few dozen clocks. Many filter histories can therefore be run: presses shorter than three cycles, single presses, several keys changing in one row, and random noise on the returns during the LED slot.

// File: rtl/kps_pkg.sv
package kps_pkg;

    // Number of identical consecutive readings needed before a key flips.
    localparam int unsigned STABLE_READS = 3;

    typedef enum logic {
        PH_KEYS = 1'b0,
        PH_LEDS = 1'b1
    } scan_phase_e;

endpackage

// File: rtl/kps_slot_seq.sv
module kps_slot_seq
    import kps_pkg::*;
#(
    parameter int unsigned NUM_STROBE = 8,
    parameter int unsigned DWELL_W    = 8,
    parameter int unsigned SLOT_W     = $clog2(NUM_STROBE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DWELL_W-1:0] dwell,
    output logic [SLOT_W-1:0]  slot_o,
    output scan_phase_e        phase_o,
    output logic               sample_o
);

    localparam logic [SLOT_W-1:0] LED_SLOT = SLOT_W'(NUM_STROBE);

    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        logic [DWELL_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic slot_end;

    always_comb begin
        s_d      = s_q;
        // A zero dwell ends the slot on its first cycle, same as one.
        slot_end = ((DWELL_W+1)'(s_q.cnt) + (DWELL_W+1)'(1)) >= (DWELL_W+1)'(dwell);
        if (slot_end) begin
            s_d.cnt  = '0;
            s_d.slot = (s_q.slot == LED_SLOT) ? '0 : s_q.slot + SLOT_W'(1);
        end else begin
            s_d.cnt  = s_q.cnt + DWELL_W'(1);
        end
        phase_o  = (s_q.slot == LED_SLOT) ? PH_LEDS : PH_KEYS;
        sample_o = slot_end && (phase_o == PH_KEYS);
        slot_o   = s_q.slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: the slot index never leaves the row range plus the LED slot
    a_r2_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.slot <= LED_SLOT);

    // R3: the last row reading is followed by the LED slot
    a_r3_led_after_last_row: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.slot == SLOT_W'(NUM_STROBE - 1) && sample_o) |=> (phase_o == PH_LEDS));

    // R2: the end of the LED slot restarts at row 0
    a_r2_wrap_to_row0: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_LEDS && slot_end) |=> (s_q.slot == '0 && s_q.cnt == '0));

endmodule

// File: rtl/kps_debounce.sv
module kps_debounce #(
    parameter int unsigned NUM_STROBE   = 8,
    parameter int unsigned NUM_RETURN   = 4,
    parameter int unsigned STABLE_READS = 3,
    parameter int unsigned SLOT_W       = 4,
    parameter int unsigned KEYS         = NUM_STROBE * NUM_RETURN
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_i,
    input  logic [SLOT_W-1:0]     row_i,
    input  logic [NUM_RETURN-1:0] ret_n_i,
    output logic [KEYS-1:0]       keys_o,
    output logic                  change_o
);

    localparam int unsigned HIST = STABLE_READS - 1;

    typedef struct packed {
        logic [KEYS-1:0]            state;
        logic [HIST-1:0][KEYS-1:0]  hist;
        logic                       change;
    } deb_t;

    deb_t d, q;
    logic [NUM_STROBE-1:0] row_hit;

    for (genvar g = 0; g < NUM_STROBE; g++) begin : g_row
        assign row_hit[g] = sample_i && (row_i == SLOT_W'(g));
    end

    always_comb begin
        logic now_b;
        logic agree_b;
        d        = q;
        d.change = 1'b0;
        now_b    = 1'b0;
        agree_b  = 1'b0;
        for (int s = 0; s < NUM_STROBE; s++) begin
            if (row_hit[s]) begin
                for (int r = 0; r < NUM_RETURN; r++) begin
                    now_b   = ~ret_n_i[r];
                    agree_b = 1'b1;
                    for (int h = 0; h < HIST; h++) begin
                        if (q.hist[h][s*NUM_RETURN + r] != now_b) agree_b = 1'b0;
                    end
                    if (agree_b && (now_b != q.state[s*NUM_RETURN + r])) begin
                        d.state[s*NUM_RETURN + r] = now_b;
                        d.change                  = 1'b1;
                    end
                    d.hist[0][s*NUM_RETURN + r] = now_b;
                    for (int h = 1; h < HIST; h++) begin
                        d.hist[h][s*NUM_RETURN + r] = q.hist[h-1][s*NUM_RETURN + r];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign keys_o   = q.state;
    assign change_o = q.change;

    // R5: filtered state moves only at the edge that takes a reading
    a_r5_change_only_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.state) |-> $past(sample_i));

    // R7: a pulse always comes with a new state value
    a_r7_pulse_has_change: assert property (@(posedge clk) disable iff (!rst_n)
        q.change |-> (q.state != $past(q.state)));

    // R7: no pulse means the state held
    a_r7_quiet_is_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !q.change |-> $stable(q.state));

endmodule

// File: rtl/kps_panel_scanner.sv
module kps_panel_scanner
    import kps_pkg::*;
#(
    parameter int unsigned NUM_STROBE   = 8,
    parameter int unsigned NUM_RETURN   = 4,
    parameter int unsigned DWELL_W      = 8,
    parameter int unsigned STABLE_READS = kps_pkg::STABLE_READS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [DWELL_W-1:0]               dwell_cycles,
    input  logic [NUM_STROBE-1:0]            led_pattern,
    input  logic [NUM_RETURN-1:0]            ret_n,
    output logic [NUM_STROBE-1:0]            strobe_n,
    output logic                             led_phase,
    output logic [NUM_STROBE*NUM_RETURN-1:0] key_down,
    output logic                             key_changed
);

    localparam int unsigned KEYS   = NUM_STROBE * NUM_RETURN;
    localparam int unsigned SLOT_W = $clog2(NUM_STROBE + 1);

    logic [SLOT_W-1:0]     slot;
    scan_phase_e           phase;
    logic                  sample;
    logic [NUM_STROBE-1:0] row_sel;

    kps_slot_seq #(
        .NUM_STROBE (NUM_STROBE),
        .DWELL_W    (DWELL_W),
        .SLOT_W     (SLOT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .dwell    (dwell_cycles),
        .slot_o   (slot),
        .phase_o  (phase),
        .sample_o (sample)
    );

    kps_debounce #(
        .NUM_STROBE   (NUM_STROBE),
        .NUM_RETURN   (NUM_RETURN),
        .STABLE_READS (STABLE_READS),
        .SLOT_W       (SLOT_W),
        .KEYS         (KEYS)
    ) u_deb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .row_i    (slot),
        .ret_n_i  (ret_n),
        .keys_o   (key_down),
        .change_o (key_changed)
    );

    for (genvar g = 0; g < NUM_STROBE; g++) begin : g_strobe
        assign row_sel[g] = (slot == SLOT_W'(g));
    end

    assign led_phase = (phase == PH_LEDS);
    assign strobe_n  = led_phase ? led_pattern : ~row_sel;

    // R2: a key slot drives exactly one strobe low
    a_r2_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        !led_phase |-> ($countones(~strobe_n) == 1));

    // R3: the LED slot carries the pattern on the strobe lines
    a_r3_pattern_out: assert property (@(posedge clk) disable iff (!rst_n)
        led_phase |-> (strobe_n == led_pattern));

    // R6: filtered keys never move at an edge that closes an LED cycle
    a_r6_led_slot_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (led_phase && $past(led_phase)) |-> $stable(key_down));

endmodule

// File: tb/tb_kps_panel_scanner.sv
module tb_kps_panel_scanner;

    localparam int NS = 8;
    localparam int NR = 4;
    localparam int DW = 8;
    localparam int NK = NS * NR;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] dwell;
    logic [NS-1:0] led_pat;
    logic [NR-1:0] ret_n;
    logic [NS-1:0] strobe_n;
    logic          led_phase;
    logic [NK-1:0] key_down;
    logic          key_changed;

    logic [NK-1:0] press;
    logic [NR-1:0] noise;
    logic [NK-1:0] m_st, m_h1, m_h2;
    int            checks = 0;
    int            fails  = 0;
    int            pulses = 0;
    bit            done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kps_panel_scanner #(.NUM_STROBE(NS), .NUM_RETURN(NR), .DWELL_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .dwell_cycles(dwell), .led_pattern(led_pat),
        .ret_n(ret_n), .strobe_n(strobe_n), .led_phase(led_phase),
        .key_down(key_down), .key_changed(key_changed)
    );

    // Panel model: a closed key pulls its column low while its row is strobed.
    always_comb begin
        logic acc;
        for (int r = 0; r < NR; r++) begin
            acc = 1'b0;
            for (int s = 0; s < NS; s++)
                if (!strobe_n[s] && press[s*NR + r]) acc = 1'b1;
            ret_n[r] = led_phase ? noise[r] : ~acc;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance to the first negedge of the next LED slot, counting pulses.
    task automatic next_scan();
        pulses = 0;
        while (led_phase) begin @(negedge clk); pulses += int'(key_changed); end
        while (!led_phase) begin @(negedge clk); pulses += int'(key_changed); end
    endtask

    task automatic model_step(output int rows);
        logic [NK-1:0] nst;
        nst = m_st;
        for (int k = 0; k < NK; k++)
            if (press[k] == m_h1[k] && press[k] == m_h2[k] && press[k] != m_st[k])
                nst[k] = press[k];
        m_h2 = m_h1;
        m_h1 = press;
        rows = 0;
        for (int s = 0; s < NS; s++)
            if (nst[s*NR +: NR] != m_st[s*NR +: NR]) rows++;
        m_st = nst;
    endtask

    task automatic run_scan();
        int rows;
        next_scan();
        model_step(rows);
        check(key_down == m_st, "R5", "key_down vs model", 64'(key_down), 64'(m_st));
        check(pulses == rows, "R7", "pulse count", 64'(pulses), 64'(rows));
    endtask

    task automatic measure_slots(input int eff, input string req);
        int n;
        while (!led_phase) @(negedge clk);
        while (led_phase) @(negedge clk);
        for (int s = 0; s < NS; s++) begin
            n = 0;
            while (!led_phase && strobe_n == ~(NS'(1) << s)) begin n++; @(negedge clk); end
            check(n == eff, req, $sformatf("row %0d slot length", s), 64'(n), 64'(eff));
        end
        n = 0;
        while (led_phase && strobe_n == led_pat) begin n++; @(negedge clk); end
        check(n == eff, "R3", "LED slot length with pattern", 64'(n), 64'(eff));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; dwell = DW'(2); led_pat = 8'hA5;
        press = '0; noise = '0;
        m_st = '0; m_h1 = '0; m_h2 = '0;
        repeat (3) @(negedge clk);
        check(key_down == '0 && !key_changed, "R1", "keys in reset", 64'(key_down), 64'(0));
        rst_n = 1'b1;
        check(strobe_n == 8'hFE, "R1", "strobe after reset", 64'(strobe_n), 64'hFE);
        check(!led_phase, "R1", "led flag after reset", 64'(led_phase), 64'(0));
        check(!key_changed, "R1", "pulse after reset", 64'(key_changed), 64'(0));

        // Slot order and lengths
        measure_slots(2, "R2");
        dwell = DW'(5); led_pat = 8'h3C;
        measure_slots(5, "R2");
        dwell = DW'(0);
        measure_slots(1, "R8");
        dwell = DW'(1); led_pat = 8'h00;
        measure_slots(1, "R2");

        // Returns during the LED slot read as all pressed
        while (!led_phase) @(negedge clk);
        noise = '0;
        repeat (4) run_scan();
        check(key_down == '0, "R6", "LED slot noise ignored", 64'(key_down), 64'(0));

        // Short press is filtered out, third reading takes effect
        press = NK'(1) << 5;
        run_scan(); run_scan();
        check(key_down[5] == 1'b0, "R5", "key 5 after two readings", 64'(key_down[5]), 64'(0));
        press = '0;
        run_scan();
        press = NK'(1) << 5;
        run_scan(); run_scan();
        check(key_down[5] == 1'b0, "R5", "key 5 after two more", 64'(key_down[5]), 64'(0));
        run_scan();
        check(key_down[5] == 1'b1, "R5", "key 5 after three", 64'(key_down[5]), 64'(1));

        // Index map: row 6 column 2 is bit 26
        press = NK'(1) << 26;
        repeat (3) run_scan();
        check(key_down == (NK'(1) << 26), "R4", "row 6 col 2", 64'(key_down), 64'(NK'(1) << 26));

        // Two keys in one row give one pulse
        press = (NK'(1) << 12) | (NK'(1) << 15);
        repeat (3) run_scan();
        check(key_down == press, "R4", "row 3 keys", 64'(key_down), 64'(press));

        // Random histories with noisy LED slots
        for (int i = 0; i < 60; i++) begin
            dwell = DW'(1 + ($urandom % 3));
            noise = NR'($urandom);
            led_pat = NS'($urandom);
            if (($urandom % 4) == 0) press = press ^ NK'($urandom & $urandom);
            else if (($urandom % 3) == 0) press = press ^ (NK'(1) << ($urandom % NK));
            run_scan();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule